// File: doc/BRIEF.md
# Multibit Trie Route Lookup Engine

The engine resolves a 32-bit IPv4 destination address to a forwarding decision by walking a multibit trie held in an on-chip RAM. The first step uses the eight most significant address bits as a direct index into a 256-entry root table. Each further step takes the next four address bits and picks one of sixteen child slots of the node it has reached. Each entry may carry a result. The engine keeps the most recent result it has seen and reports it when the walk ends. If no result was seen, it reports a drop.

Lookups are handled one at a time. A request is accepted only while the engine is idle. The result comes back as a one-cycle pulse, after which the engine takes the next request. The trie image is written through a simple load port. Software computes the image, and how routes are inserted into it is left to that software.

Top module: `trie_lookup_engine`

## Requirements
- R1: The first RAM read of a lookup is at RAM address `req_addr[31:24]`. The root table occupies RAM addresses 0 to 255.
- R2: Each later read is at `child_base + nibble`. The nibbles are taken most significant first: `req_addr[23:20]`, then `[19:16]`, then `[15:12]`, then `[11:8]`.
- R3: An entry is 18 bits wide (defaults IF_W=6, MEM_AW=10), with these fields:
  - bit 17 is the pointer flag (1 = pointer, 0 = leaf).
  - bit 16 is the result-valid flag.
  - bits 15:10 are the interface code.
  - bits 9:0 are the child base.
  - In a leaf entry the child base is ignored.
- R4: Every entry read with its result-valid flag set replaces the remembered result. The reported interface is the last valid result seen on the walk.
- R5: The walk ends at a leaf entry, or at a pointer entry whose child base is 0. The remembered result is then reported.
- R6: A walk makes at most five reads. A pointer found in the fifth read ends the walk, and `req_addr[7:0]` never affects the outcome.
- R7: When no valid result was seen on the walk, `res_drop` is 1 and `res_iface` is 0.
- R8: The result timing is as follows:
  - For a walk of n reads, `res_valid` is high for exactly one cycle.
  - That cycle begins 2n clock edges after the edge that accepted the request.
  - `res_drop` and `res_iface` are valid in that cycle.
- R9: `req_ready` falls on the accepting edge and stays low until the edge that ends the result pulse. A request held during that time is not taken, and it produces no extra result.
- R10: A word written through the load port while the engine is idle is used by every later lookup.
- R11: After reset, `req_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request taken on this edge |
| req_addr | input | 32 | Destination address |
| res_valid | output | 1 | One-cycle result pulse |
| res_drop | output | 1 | No route found |
| res_iface | output | IF_W | Interface code of the match |
| ld_en | input | 1 | Write one trie word |
| ld_addr | input | MEM_AW | Word address of the write |
| ld_data | input | ENTRY_W | Word to write |

## Verification
Each read costs two cycles: one to present the address to the registered RAM and one to decode the word. A lookup of n reads therefore pulses its result 2n edges after acceptance. For every request the bench records the cycle count at the falling edge where it drives the request, together with the expected read count. The result is compared at the falling edge inside the pulse, and the elapsed count must equal 2n+1. The chosen addresses give walks of one, two, three and five reads, so a result that arrives one decode early or late is reported as a mismatch.

// File: rtl/trie_lookup_engine.sv
module trie_lookup_engine #(
  parameter int IF_W        = 6,
  parameter int MEM_AW      = 10,
  parameter int LATER_STEPS = 4,
  localparam int ENTRY_W    = 2 + IF_W + MEM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_addr,
  output logic               res_valid,
  output logic               res_drop,
  output logic [IF_W-1:0]    res_iface,
  input  logic               ld_en,
  input  logic [MEM_AW-1:0]  ld_addr,
  input  logic [ENTRY_W-1:0] ld_data
);
  localparam int ROOT_W = 8;
  localparam int STEP_W = 4;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int LVL_W  = $clog2(LATER_STEPS + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_DECODE, S_DONE} st_t;

  st_t                st;
  logic [31:0]        addr_q;
  logic [MEM_AW-1:0]  rd_addr;
  logic [ENTRY_W-1:0] rdata;
  logic [LVL_W-1:0]   lvl;
  logic               best_v;
  logic [IF_W-1:0]    best_if;
  logic [ENTRY_W-1:0] mem [DEPTH];

  wire              e_ptr  = rdata[ENTRY_W-1];
  wire              e_val  = rdata[ENTRY_W-2];
  wire [IF_W-1:0]   e_if   = rdata[ENTRY_W-3 -: IF_W];
  wire [MEM_AW-1:0] e_base = rdata[MEM_AW-1:0];

  logic [5:0]        shamt;
  logic [31:0]       shifted;
  logic [3:0]        nib;
  logic [MEM_AW-1:0] next_addr;
  logic              descend;

  assign shamt     = 6'(ROOT_W) + 6'(STEP_W) * 6'(lvl);
  assign shifted   = addr_q << shamt;
  assign nib       = shifted[31:28];
  assign next_addr = e_base + MEM_AW'(nib);
  assign descend   = e_ptr && (e_base != '0) && (lvl < LVL_W'(LATER_STEPS));

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    rdata <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      rd_addr <= '0;
      lvl     <= '0;
      best_v  <= 1'b0;
      best_if <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          rd_addr <= MEM_AW'(req_addr[31:24]);
          lvl     <= '0;
          best_v  <= 1'b0;
          best_if <= '0;
          st      <= S_READ;
        end
        S_READ: st <= S_DECODE;
        S_DECODE: begin
          if (e_val) begin
            best_v  <= 1'b1;
            best_if <= e_if;
          end
          if (descend) begin
            rd_addr <= next_addr;
            lvl     <= lvl + 1'b1;
            st      <= S_READ;
          end else begin
            st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign res_valid = (st == S_DONE);
  assign res_drop  = !best_v;
  assign res_iface = best_v ? best_if : '0;

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_from_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(st) == S_DECODE);
  p_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> req_ready);
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !res_valid) |=> $stable(addr_q));
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DECODE) |-> (lvl <= LVL_W'(LATER_STEPS)));
endmodule

// File: tb/sim_trie_lookup_engine.sv
`timescale 1ns/1ps
module sim_trie_lookup_engine;
  localparam int IF_W = 6;
  localparam int MEM_AW = 10;
  localparam int ENTRY_W = 2 + IF_W + MEM_AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_addr = '0;
  logic res_valid, res_drop;
  logic [IF_W-1:0] res_iface;
  logic ld_en = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [ENTRY_W-1:0] ld_data = '0;

  trie_lookup_engine #(.IF_W(IF_W), .MEM_AW(MEM_AW), .LATER_STEPS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .res_valid(res_valid), .res_drop(res_drop),
    .res_iface(res_iface), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int q_drop[$], q_if[$], q_reads[$], q_cyc[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [ENTRY_W-1:0] mk(input bit p, input bit v, input int ifc, input int base);
    return {p, v, IF_W'(ifc), MEM_AW'(base)};
  endfunction

  task automatic load(input int a, input logic [ENTRY_W-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = MEM_AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic push(input bit dr, input int ifc, input int rd, input string tag);
    q_drop.push_back(int'(dr)); q_if.push_back(ifc); q_reads.push_back(rd);
    q_cyc.push_back(cyc); q_tag.push_back(tag);
  endtask

  task automatic lookup(input logic [31:0] a, input bit dr, input int ifc, input int rd, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    push(dr, ifc, rd, tag);
    @(negedge clk);
    req_valid = 1'b0;
    while (q_drop.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q_drop.size() == 0) begin
        chk(1'b0, "R9", "unexpected result", 1, 0);
      end else begin
        automatic int edr = q_drop.pop_front();
        automatic int eif = q_if.pop_front();
        automatic int erd = q_reads.pop_front();
        automatic int ec  = q_cyc.pop_front();
        automatic string t = q_tag.pop_front();
        chk(int'(res_drop) == edr, t, "drop", int'(res_drop), edr);
        chk(int'(res_iface) == eif, t, "iface", int'(res_iface), eif);
        chk(cyc - ec == 2 * erd + 1, {t, " R8"}, "latency", cyc - ec, 2 * erd + 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "req_ready", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R11", "res_valid", int'(res_valid), 0);

    for (int i = 0; i < (1 << MEM_AW); i++) load(i, '0);
    load(10, mk(0, 1, 3, 0));
    load(20, mk(1, 1, 5, 256));
    load(256 + 7, mk(0, 1, 9, 0));
    load(256 + 2, mk(1, 0, 0, 272));
    load(256 + 4, mk(1, 1, 14, 0));
    load(272 + 10, mk(0, 1, 12, 0));
    load(30, mk(1, 0, 0, 288));
    load(288 + 1, mk(1, 0, 0, 304));
    load(304 + 2, mk(1, 0, 0, 320));
    load(320 + 3, mk(1, 1, 21, 336));
    load(336 + 4, mk(1, 1, 22, 352));
    load(352, mk(0, 1, 40, 0));
    load(40, mk(1, 0, 0, 0));
    load(50, mk(0, 1, 7, 400));

    lookup(32'h0A010203, 0, 3, 1, "R1 root leaf");
    lookup(32'h14700000, 0, 9, 2, "R2 second level");
    lookup(32'h142A0000, 0, 12, 3, "R2 third level");
    lookup(32'h142B0000, 0, 5, 3, "R4 remembered result");
    lookup(32'h14400000, 0, 14, 2, "R5 null pointer");
    lookup(32'h14000000, 0, 5, 2, "R4 empty leaf falls back");
    lookup(32'h1E123400, 0, 22, 5, "R6 depth bound");
    lookup(32'h1E1234FF, 0, 22, 5, "R6 low byte ignored");
    lookup(32'h28000000, 1, 0, 1, "R7 null root pointer");
    lookup(32'h00000000, 1, 0, 1, "R7 empty root");
    lookup(32'h32000000, 0, 7, 1, "R3 leaf base ignored");

    // R9: hold the request while busy
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h1E123400;
    push(0, 22, 5, "R9 held request");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R9", "req_ready while busy", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    while (q_drop.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R8", "pulse width", int'(res_valid), 0);
    chk(req_ready == 1'b1, "R9", "ready after result", int'(req_ready), 1);
    repeat (4) @(negedge clk);

    load(10, mk(0, 1, 33, 0));
    lookup(32'h0AFFFFFF, 0, 33, 1, "R10 reload");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule